// File: doc/BRIEF.md
# Adaptive Shortcut Utilization Controller

This controller sits next to a mesh router that also has access to a set of long-range express shortcuts. For every packet that asks for a route, it decides whether the packet may take the shortest path, which may use a shortcut, or must fall back to dimension-ordered mesh routing. The share of packets that are allowed onto the shortest path is a utilization percentage. The controller keeps this percentage and grants exactly that many requests out of every hundred consecutive requests.

The percentage is tuned in a closed loop. The controller counts flits sent and router stall cycles over fixed-length measurement windows. A window is congested when stalls outweigh two thirds of the flits sent. Two policies can be selected. In the lock-once policy, the first congested window lowers the percentage by one step and freezes it until the next reset. In the adaptive policy, the controller also freezes on congestion but records the traffic it saw. When either count later moves by more than one and a half times its recorded value, it thaws and resumes searching. While searching, quiet windows push the percentage back up.

Top module: `shortcut_util_ctrl`

## Requirements
- R1: While reset is held and right after it, the utilization output reads 100, the locked output is 0 and no packet is granted.
- R2: A grant is given only in a cycle with a packet request, and only when a modulo-100 ticket is below the utilization. The ticket advances by one per request and wraps from 99 to 0. As a result, any 100 consecutive requests receive exactly as many grants as the utilization value, and none when the utilization is 0.
- R3: Measurement windows are consecutive runs of PERIOD_CYCLES clock edges, the first one beginning at the first edge after reset is released. Each window counts the edges on which the flit input and the stall input are high, and its verdict is visible on the outputs right after its last edge.
- R4: A window is congested exactly when 3 times its stall count exceeds 2 times its flit count. Equality is not congestion.
- R5: With mode_adaptive at 0 and the controller searching, a congested window lowers the utilization by STEP_PCT and sets locked. An uncongested window leaves the utilization unchanged.
- R6: With mode_adaptive at 0 and locked set, the utilization and locked never change until reset, whatever the traffic.
- R7: With mode_adaptive at 1 and the controller searching, a congested window lowers the utilization by STEP_PCT, sets locked and records both window counts. An uncongested window raises the utilization by STEP_PCT.
- R8: With mode_adaptive at 1 and locked set, a window clears locked when, for the flit count or the stall count, 2 times the absolute difference from the recorded value exceeds 3 times the recorded value. That window leaves the utilization unchanged. A difference of exactly 150 percent does not clear locked.
- R9: The utilization never falls below 0 and never rises above 100. A step that would cross either limit stops at the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| mode_adaptive | input | 1 | 0 selects the lock-once policy, 1 selects the adaptive policy |
| flit_sent | input | 1 | High for each cycle in which the router sent a flit |
| stall | input | 1 | High for each cycle in which the router stalled |
| pkt_req | input | 1 | A packet asks for a routing decision this cycle |
| use_shortcut | output | 1 | Same-cycle answer: 1 means take the shortest path, 0 means mesh routing |
| util_pct | output | 7 | Current utilization percentage, 0 to 100 |
| locked | output | 1 | The utilization is frozen |

## Verification
The bench drives traffic window by window, aligned to the boundaries it derives from reset. This lets it place exact stall and flit counts on the congestion threshold and on the 150 percent thaw threshold.

- If the congestion comparison used greater-or-equal, the bench would see a lock when stalls equal two thirds of flits.
- If the thaw test were off by one, the bench would see a release at exactly 150 percent.
- A lock-once controller that obeyed the thaw rule would start moving again after a large traffic jump, which the bench provokes on purpose.

The bench also runs the adaptive lock-and-thaw cycle repeatedly until the utilization reaches its floor, where a wrapping subtraction would show a value far above 100. Finally, it counts grants over blocks of 100 requests at 100, 90 and 0 percent.

// File: rtl/sc_util_pkg.sv
package sc_util_pkg;
  localparam int unsigned PCT_W = 7;
  localparam logic [PCT_W-1:0] PCT_FULL = 7'd100;
  localparam logic [PCT_W-1:0] TICKET_LAST = 7'd99;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_FROZEN = 1'b1
  } util_state_e;
endpackage

// File: rtl/su_sat_acc.sv
module su_sat_acc #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] tot_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (inc_i && (cnt_q != {W{1'b1}})) tot_o = cnt_q + W'(1);
    else                               tot_o = cnt_q;
    cnt_d = clr_i ? '0 : tot_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/su_period_cnt.sv
module su_period_cnt #(
  parameter int unsigned PERIOD_CYCLES = 1024,
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ev_i,
  output logic             last_o,
  output logic [CNT_W-1:0] tot_o [2]
);
  localparam int unsigned CYC_W = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(PERIOD_CYCLES - 1);

  logic [CYC_W-1:0] cyc_q;
  logic [CYC_W-1:0] cyc_d;

  always_comb begin
    last_o = (cyc_q == CYC_LAST);
    cyc_d  = last_o ? '0 : cyc_q + CYC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end

  for (genvar g = 0; g < 2; g++) begin : g_acc
    su_sat_acc #(.W(CNT_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (ev_i[g]),
      .clr_i (last_o),
      .tot_o (tot_o[g])
    );
  end
endmodule

// File: rtl/su_util_fsm.sv
module su_util_fsm
  import sc_util_pkg::*;
#(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned STEP_PCT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adaptive_i,
  input  logic             eval_i,
  input  logic [CNT_W-1:0] flit_tot_i,
  input  logic [CNT_W-1:0] stall_tot_i,
  output logic [PCT_W-1:0] util_o,
  output logic             locked_o
);
  localparam int unsigned XW = CNT_W + 2;

  util_state_e      state_q, state_d;
  logic [PCT_W-1:0] util_q, util_d;
  logic [CNT_W-1:0] rec_flit_q, rec_stall_q;
  logic             rec_en;
  logic             congested;
  logic             moved_flit, moved_stall;
  logic [PCT_W:0]   util_up;
  logic [PCT_W-1:0] util_inc, util_dec;

  function automatic logic [XW-1:0] times3(input logic [CNT_W-1:0] v);
    return ({2'b00, v} << 1) + {2'b00, v};
  endfunction

  function automatic logic big_move(input logic [CNT_W-1:0] now_v,
                                    input logic [CNT_W-1:0] rec_v);
    logic [CNT_W-1:0] diff;
    diff = (now_v >= rec_v) ? (now_v - rec_v) : (rec_v - now_v);
    return {1'b0, diff, 1'b0} > times3(rec_v);
  endfunction

  always_comb begin
    congested   = times3(stall_tot_i) > {1'b0, flit_tot_i, 1'b0};
    moved_flit  = big_move(flit_tot_i, rec_flit_q);
    moved_stall = big_move(stall_tot_i, rec_stall_q);
    util_up     = {1'b0, util_q} + (PCT_W+1)'(STEP_PCT);
    util_inc    = (util_up >= {1'b0, PCT_FULL}) ? PCT_FULL : util_up[PCT_W-1:0];
    util_dec    = (util_q >= PCT_W'(STEP_PCT)) ? (util_q - PCT_W'(STEP_PCT)) : '0;
  end

  always_comb begin
    state_d = state_q;
    util_d  = util_q;
    rec_en  = 1'b0;
    if (eval_i) begin
      unique case (state_q)
        ST_SEARCH: begin
          if (congested) begin
            util_d  = util_dec;
            state_d = ST_FROZEN;
            rec_en  = 1'b1;
          end else if (adaptive_i) begin
            util_d = util_inc;
          end
        end
        ST_FROZEN: begin
          if (adaptive_i && (moved_flit || moved_stall)) state_d = ST_SEARCH;
        end
        default: state_d = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      util_q  <= PCT_FULL;
    end else begin
      state_q <= state_d;
      util_q  <= util_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_flit_q  <= '0;
      rec_stall_q <= '0;
    end else if (rec_en) begin
      rec_flit_q  <= flit_tot_i;
      rec_stall_q <= stall_tot_i;
    end
  end

  assign util_o   = util_q;
  assign locked_o = (state_q == ST_FROZEN);
endmodule

// File: rtl/su_ticket.sv
module su_ticket
  import sc_util_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [PCT_W-1:0] util_i,
  output logic             grant_o
);
  logic [PCT_W-1:0] tk_q, tk_d;

  always_comb begin
    grant_o = req_i && (tk_q < util_i);
    tk_d    = (tk_q == TICKET_LAST) ? '0 : tk_q + PCT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tk_q <= '0;
    else if (req_i) tk_q <= tk_d;
  end
endmodule

// File: rtl/shortcut_util_ctrl.sv
module shortcut_util_ctrl
  import sc_util_pkg::*;
#(
  parameter int unsigned PERIOD_CYCLES = 1024,
  parameter int unsigned STEP_PCT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_adaptive,
  input  logic             flit_sent,
  input  logic             stall,
  input  logic             pkt_req,
  output logic             use_shortcut,
  output logic [PCT_W-1:0] util_pct,
  output logic             locked
);
  localparam int unsigned CNT_W = $clog2(PERIOD_CYCLES + 1);

  logic             win_last;
  logic [CNT_W-1:0] win_tot [2];

  su_period_cnt #(.PERIOD_CYCLES(PERIOD_CYCLES), .CNT_W(CNT_W)) u_period (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   ({stall, flit_sent}),
    .last_o (win_last),
    .tot_o  (win_tot)
  );

  su_util_fsm #(.CNT_W(CNT_W), .STEP_PCT(STEP_PCT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .adaptive_i  (mode_adaptive),
    .eval_i      (win_last),
    .flit_tot_i  (win_tot[0]),
    .stall_tot_i (win_tot[1]),
    .util_o      (util_pct),
    .locked_o    (locked)
  );

  su_ticket u_ticket (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (pkt_req),
    .util_i  (util_pct),
    .grant_o (use_shortcut)
  );
endmodule

// File: rtl/shortcut_util_chk.sv
module shortcut_util_chk #(
  parameter int unsigned STEP_PCT = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_adaptive,
  input logic       pkt_req,
  input logic       use_shortcut,
  input logic [6:0] util_pct,
  input logic       locked
);
  // R9
  util_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    util_pct <= 7'd100);

  // R2
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_req |-> !use_shortcut);

  // R2
  grant_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_req && util_pct == 7'd100) |-> use_shortcut);

  // R2
  grant_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (util_pct == 7'd0) |-> !use_shortcut);

  // R6
  search_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !mode_adaptive) |=> (locked && $stable(util_pct)));

  // R7
  util_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(util_pct) |->
      (int'(util_pct) == int'($past(util_pct)) + int'(STEP_PCT) ||
       int'(util_pct) == int'($past(util_pct)) - int'(STEP_PCT) ||
       util_pct == 7'd0 || util_pct == 7'd100));

  // R8
  thaw_keeps_util_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $stable(util_pct));
endmodule

bind shortcut_util_ctrl shortcut_util_chk #(.STEP_PCT(STEP_PCT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_adaptive (mode_adaptive),
  .pkt_req       (pkt_req),
  .use_shortcut  (use_shortcut),
  .util_pct      (util_pct),
  .locked        (locked)
);

// File: tb/shortcut_util_ctrl_tb.sv
module shortcut_util_ctrl_tb;
  localparam int P = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_adaptive = 1'b0;
  logic       flit_sent = 1'b0;
  logic       stall = 1'b0;
  logic       pkt_req = 1'b0;
  logic       use_shortcut;
  logic [6:0] util_pct;
  logic       locked;

  int checks = 0;
  int errors = 0;
  int grants = 0;
  int exp_util = 0;

  always #10 clk = ~clk;

  shortcut_util_ctrl #(.PERIOD_CYCLES(P), .STEP_PCT(10)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_adaptive (mode_adaptive),
    .flit_sent     (flit_sent),
    .stall         (stall),
    .pkt_req       (pkt_req),
    .use_shortcut  (use_shortcut),
    .util_pct      (util_pct),
    .locked        (locked)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic adaptive);
    rst_n = 1'b0;
    mode_adaptive = adaptive;
    flit_sent = 1'b0; stall = 1'b0; pkt_req = 1'b0;
    repeat (3) @(negedge clk);
    #5;
    check("R1 util in reset", int'(util_pct), 100);
    check("R1 locked in reset", int'(locked), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one measurement window: nf flit cycles, ns stall cycles, nr requests
  task automatic window(input int nf, input int ns, input int nr);
    grants = 0;
    for (int i = 0; i < P; i++) begin
      flit_sent = (i < nf);
      stall     = (i < ns);
      pkt_req   = (i < nr);
      #5;
      if (use_shortcut) grants++;
      @(posedge clk);
      @(negedge clk);
    end
    flit_sent = 1'b0; stall = 1'b0; pkt_req = 1'b0;
  endtask

  task automatic grant_run(input string tag, input int exp);
    int total;
    total = 0;
    for (int w = 0; w < 5; w++) begin
      window(0, 0, P);
      total += grants;
    end
    check(tag, total, exp);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    check("R1 util after reset", int'(util_pct), 100);
    check("R1 locked after reset", int'(locked), 0);
    window(0, 0, 0);
    check("R2 no grant without request", grants, 0);
  endtask

  task automatic t_lock_once;
    grant_run("R2 grants at 100", 100);
    check("R5 quiet windows keep util", int'(util_pct), 100);
    window(20, 13, 0);
    check("R4 below threshold no lock", int'(locked), 0);
    window(15, 10, 0);
    check("R4 equality not congested", int'(locked), 0);
    check("R3 util after equality window", int'(util_pct), 100);
    window(0, 1, 0);
    check("R5 congestion lowers util", int'(util_pct), 90);
    check("R5 congestion locks", int'(locked), 1);
    window(20, 20, 0);
    window(20, 0, 0);
    check("R6 traffic jump ignored util", int'(util_pct), 90);
    check("R6 traffic jump ignored lock", int'(locked), 1);
    grant_run("R2 grants at 90", 90);
  endtask

  task automatic t_adaptive;
    do_reset(1'b1);
    window(0, 0, 0);
    check("R9 raise capped at 100", int'(util_pct), 100);
    window(8, 6, 0);
    check("R7 congestion lowers util", int'(util_pct), 90);
    check("R7 congestion locks", int'(locked), 1);
    window(20, 6, 0);
    check("R8 flit change of exactly 150pct keeps lock", int'(locked), 1);
    window(8, 15, 0);
    check("R8 stall change of exactly 150pct keeps lock", int'(locked), 1);
    window(8, 16, 0);
    check("R8 stall jump thaws", int'(locked), 0);
    check("R8 thaw keeps util", int'(util_pct), 90);
    window(0, 0, 0);
    check("R7 quiet window raises util", int'(util_pct), 100);
    window(0, 1, 0);
    check("R7 relock", int'(util_pct), 90);
    exp_util = 90;
    for (int k = 0; k < 10; k++) begin
      window(1, 1, 0);
      check("R8 flit rise thaws", int'(locked), 0);
      check("R8 thaw window util", int'(util_pct), exp_util);
      window(0, 1, 0);
      exp_util = (exp_util >= 10) ? exp_util - 10 : 0;
      check("R9 sweep toward floor", int'(util_pct), exp_util);
      check("R7 lock after sweep step", int'(locked), 1);
    end
    check("R9 floor at zero", int'(util_pct), 0);
    grant_run("R2 grants at 0", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_lock_once();
    t_adaptive();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule